// File: doc/BRIEF.md
# I2C Target with 16-bit Register Bank

This block is an I2C target. It answers on one 7-bit device address and on one shared broadcast address. Behind it sits a small bank of 16-bit registers:

- a configuration word;
- a read-only identification/status word;
- a broadcast word;
- a write-only soft-reset location;
- a parameterised row of channel data words.

A write is an address byte, a command byte that selects the register, and two data bytes, high byte first. The register updates as a whole only once the low byte has been acknowledged.

A read normally starts with a write phase that sends the command byte. A repeated start follows, with the read bit set, and the target then shifts the selected word out, high byte first. A read that skips the command byte returns the register named by the most recent command byte.

The bus lines are sampled in the system clock domain through two-flop synchronizers. SDA is driven open-drain through a pull-low enable, and it changes only while SCL is low.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 7'h48) is ACKed. An address that is neither DEV_ADDR nor a broadcast write is NACKed (SDA left high in the ninth clock), and the target then ignores the bus until the next START.
- R2: A write is the address byte with bit0=0, the command byte, the high data byte and the low data byte. The selected register changes only after the low byte's ACK. A STOP arriving before the low byte leaves the register unchanged.
- R3: A read is set up with an address byte (bit0=0) and a command byte, followed by a repeated START and the address byte with bit0=1. The target ACKs all three bytes, then drives the high byte and after it the low byte, each most significant bit first.
- R4: A START followed directly by the address byte with bit0=1 returns the register selected by the most recent command byte.
- R5: The broadcast address BCAST_ADDR (default 7'h47) with bit0=0 is ACKed, and the write that follows updates the register exactly as a write to DEV_ADDR would.
- R6: The broadcast address with bit0=1 is NACKed, and no data is driven afterwards.
- R7: After reset the registers hold these values:
  - configuration (command 01h): 00FFh;
  - status (command 02h): STATUS_ID (default 0300h);
  - broadcast (command 03h): 0000h;
  - channel k (command 08h+k, k < NUM_CH, default 8): 0000h.
- R8: The status register is read-only. A write to command 02h is ACKed, and the register still reads STATUS_ID afterwards.
- R9: Command 04h is a write-only soft-reset register. Any completed write to it returns the configuration, broadcast and channel registers to their reset values. A read of it returns 0000h.
- R10: A command byte naming an unmapped register (for example 10h or 20h) is ACKed. Writes to it change no register, and reads of it return 0000h.
- R11: When the controller NACKs the high data byte, the read ends and the target releases SDA. After the low data byte the target releases SDA whatever the controller answers, and stays released until the next START.
- R12: The SDA pull-low enable changes only while SCL is low.
- R13: A START in the middle of any byte abandons the current transfer and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | Pulls SDA low when 1 (open-drain) |

## Verification
On every cycle the assertions check the following:
- the SDA enable never moves while the synchronized SCL is high;
- a broadcast read address or a foreign address never draws an ACK;
- the read ends after the low byte;
- the write and pointer strobes never fire together;
- the configuration register and the register pointer change only on their strobes.

The bench's scenarios are the only place where the externally visible protocol is shown. They cover:
- register values read back after writes;
- the address-only read of the last selected register;
- the unchanged register after a write aborted by STOP;
- the soft-reset effect and the read-only status word;
- recovery from a START arriving mid-byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int REG_W = 16;
  localparam int CMD_W = 8;

  // Strobes from the byte controller to the register bank
  typedef struct packed {
    logic             setPtr;
    logic [CMD_W-1:0] ptrVal;
    logic             wrEn;
    logic [REG_W-1:0] wrData;
  } bank_cmd_t;
endpackage

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_reg_pkg::*;
#(
  parameter int               NUM_CH    = 8,
  parameter logic [7:0]       CH_BASE   = 8'h08,
  parameter logic [7:0]       CFG_CMD   = 8'h01,
  parameter logic [7:0]       STAT_CMD  = 8'h02,
  parameter logic [7:0]       BC_CMD    = 8'h03,
  parameter logic [7:0]       SWRST_CMD = 8'h04,
  parameter logic [REG_W-1:0] CFG_RST   = 16'h00FF,
  parameter logic [REG_W-1:0] STATUS_ID = 16'h0300
) (
  input  logic             clk,
  input  logic             rstN,
  input  bank_cmd_t        cmd,
  output logic [REG_W-1:0] rdData
);
  logic [CMD_W-1:0] ptr;
  logic [REG_W-1:0] cfgReg;
  logic [REG_W-1:0] bcReg;
  logic [NUM_CH-1:0][REG_W-1:0] chFlat;
  logic softRst;

  assign softRst = cmd.wrEn && (ptr == SWRST_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (cmd.setPtr) ptr <= cmd.ptrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RST;
      bcReg  <= '0;
    end else if (softRst) begin
      cfgReg <= CFG_RST;
      bcReg  <= '0;
    end else if (cmd.wrEn) begin
      if (ptr == CFG_CMD) cfgReg <= cmd.wrData;
      if (ptr == BC_CMD)  bcReg  <= cmd.wrData;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [CMD_W-1:0] CH_CMD = CMD_W'(CH_BASE + i);
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (softRst) q <= '0;
      else if (cmd.wrEn && ptr == CH_CMD) q <= cmd.wrData;
    end
    assign chFlat[i] = q;
  end

  always_comb begin
    rdData = '0;
    if (ptr == CFG_CMD)  rdData = cfgReg;
    if (ptr == STAT_CMD) rdData = STATUS_ID;
    if (ptr == BC_CMD)   rdData = bcReg;
    for (int i = 0; i < NUM_CH; i++)
      if (ptr == CMD_W'(CH_BASE + i)) rdData = chFlat[i];
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setPtr, cmd.wrEn}));
  // R2
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(cmd.wrEn));
  // R4
  ptr_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> $past(cmd.setPtr));
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h48,
  parameter logic [6:0] BCAST_ADDR = 7'h47
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] rdData,
  output bank_cmd_t        bankCmd,
  output logic             sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXWAIT, S_RXACK, S_TX, S_TXACK} state_t;
  typedef enum logic [1:0] {ROLE_ADDR, ROLE_CMD, ROLE_MSB, ROLE_LSB} role_t;

  logic [1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;
  state_t state;
  role_t role, nextRole;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift, msbHold;
  logic isRead, txLsb, mAck, ackNow;

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn}; sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS; sdaPrev <= sdaS;
    end
  end

  always_comb begin
    case (role)
      ROLE_ADDR: nextRole = ROLE_CMD;
      ROLE_CMD:  nextRole = ROLE_MSB;
      ROLE_MSB:  nextRole = ROLE_LSB;
      default:   nextRole = ROLE_MSB;
    endcase
    if (role == ROLE_ADDR)
      ackNow = (rxShift[7:1] == DEV_ADDR) || (rxShift[7:1] == BCAST_ADDR && !rxShift[0]);
    else
      ackNow = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; role <= ROLE_ADDR; bitCnt <= '0; rxShift <= '0; txShift <= '0;
      msbHold <= '0; isRead <= 1'b0; txLsb <= 1'b0; mAck <= 1'b0; sdaOe <= 1'b0;
      bankCmd <= '0;
    end else begin
      bankCmd <= '0;
      if (startCond) begin
        state <= S_RX; role <= ROLE_ADDR; bitCnt <= '0; sdaOe <= 1'b0;
      end else if (stopCond) begin
        state <= S_IDLE; sdaOe <= 1'b0;
      end else begin
        case (state)
          S_RX: if (sclRise) begin
            rxShift <= {rxShift[6:0], sdaS};
            if (bitCnt == 4'd7) begin bitCnt <= '0; state <= S_RXWAIT; end
            else bitCnt <= bitCnt + 4'd1;
          end
          S_RXWAIT: if (sclFall) begin
            if (ackNow) begin sdaOe <= 1'b1; state <= S_RXACK; end
            else state <= S_IDLE;
            if (role == ROLE_ADDR) isRead <= rxShift[0];
            if (role == ROLE_CMD) begin bankCmd.setPtr <= 1'b1; bankCmd.ptrVal <= rxShift; end
            if (role == ROLE_MSB) msbHold <= rxShift;
          end
          S_RXACK: if (sclFall) begin
            if (role == ROLE_ADDR && isRead) begin
              txShift <= rdData[15:8]; sdaOe <= ~rdData[15];
              txLsb <= 1'b0; bitCnt <= '0; state <= S_TX;
            end else begin
              sdaOe <= 1'b0; state <= S_RX; role <= nextRole;
            end
            if (role == ROLE_LSB) begin
              bankCmd.wrEn <= 1'b1; bankCmd.wrData <= {msbHold, rxShift};
            end
          end
          S_TX: if (sclRise) bitCnt <= bitCnt + 4'd1;
                else if (sclFall) begin
                  if (bitCnt == 4'd8) begin sdaOe <= 1'b0; state <= S_TXACK; end
                  else sdaOe <= ~txShift[3'd7 - bitCnt[2:0]];
                end
          S_TXACK: if (sclRise) mAck <= ~sdaS;
                   else if (sclFall) begin
                     if (mAck && !txLsb) begin
                       txShift <= rdData[7:0]; sdaOe <= ~rdData[7];
                       txLsb <= 1'b1; bitCnt <= '0; state <= S_TX;
                     end else state <= S_IDLE;
                   end
          default: ;
        endcase
      end
    end
  end

  // R12
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
  // R6
  bcast_read_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RXWAIT && sclFall && !startCond && !stopCond && role == ROLE_ADDR
     && rxShift == {BCAST_ADDR, 1'b1}) |=> (!sdaOe && state == S_IDLE));
  // R1
  foreign_addr_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RXWAIT && sclFall && !startCond && !stopCond && role == ROLE_ADDR
     && rxShift[7:1] != DEV_ADDR && rxShift[7:1] != BCAST_ADDR) |=> (!sdaOe && state == S_IDLE));
  // R11
  read_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TXACK && sclFall && txLsb && !startCond && !stopCond) |=> (state == S_IDLE && !sdaOe));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]       DEV_ADDR   = 7'h48,
  parameter logic [6:0]       BCAST_ADDR = 7'h47,
  parameter int               NUM_CH     = 8,
  parameter logic [REG_W-1:0] STATUS_ID  = 16'h0300
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  bank_cmd_t        bankCmd;
  logic [REG_W-1:0] rdData;

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .bankCmd(bankCmd), .sdaOe(sdaOe)
  );

  i2c_reg_bank #(.NUM_CH(NUM_CH), .STATUS_ID(STATUS_ID)) uBank (
    .clk(clk), .rstN(rstN), .cmd(bankCmd), .rdData(rdData)
  );
endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 100;
  localparam logic [6:0] DEV = 7'h48;
  localparam logic [6:0] BC = 7'h47;
  localparam logic [15:0] SID = 16'h0300;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int checks = 0, fails = 0, sclHighMoves = 0;
  bit done = 1'b0;

  assign sdaLine = mSda & ~sdaOe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target dut (.clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe));

  always @(sdaOe) if (rstN && mScl) sclHighMoves++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2cStart();
    mSda = 1'b1; #Q; mScl = 1'b1; #Q; mSda = 1'b0; #Q; mScl = 1'b0; #Q;
  endtask
  task automatic i2cStop();
    mSda = 1'b0; #Q; mScl = 1'b1; #Q; mSda = 1'b1; #Q;
  endtask
  task automatic bitOut(input logic b);
    mSda = b; #Q; mScl = 1'b1; #Q; #Q; mScl = 1'b0; #Q;
  endtask
  task automatic bitIn(output logic b);
    mSda = 1'b1; #Q; mScl = 1'b1; #Q; b = sdaLine; #Q; mScl = 1'b0; #Q;
  endtask
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(b); ack = ~b;
  endtask
  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitIn(v[i]);
    bitOut(~ackIt);
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d, output logic ok);
    logic a0, a1, a2, a3;
    i2cStart(); sendByte({a, 1'b0}, a0); sendByte(c, a1);
    sendByte(d[15:8], a2); sendByte(d[7:0], a3); i2cStop();
    ok = a0 & a1 & a2 & a3;
  endtask
  task automatic regRead(input logic [7:0] c, output logic [15:0] d, output logic ok);
    logic a0, a1, a2;
    i2cStart(); sendByte({DEV, 1'b0}, a0); sendByte(c, a1);
    i2cStart(); sendByte({DEV, 1'b1}, a2);
    recvByte(1'b1, d[15:8]); recvByte(1'b0, d[7:0]); i2cStop();
    ok = a0 & a1 & a2;
  endtask

  task automatic tReset();
    logic [15:0] d; logic ok;
    regRead(8'h01, d, ok); chk("R7 cfg reset", d, 16'h00FF); chk("R3 read acks", 16'(ok), 16'h1);
    regRead(8'h02, d, ok); chk("R7 status reset", d, SID);
    regRead(8'h03, d, ok); chk("R7 bcast reset", d, 16'h0000);
    regRead(8'h0D, d, ok); chk("R7 channel reset", d, 16'h0000);
  endtask

  task automatic tWriteRead();
    logic [15:0] d; logic ok;
    regWrite(DEV, 8'h0B, 16'h1234, ok); chk("R1 own address write acks", 16'(ok), 16'h1);
    regWrite(DEV, 8'h0F, 16'hBEEF, ok);
    regWrite(DEV, 8'h03, 16'h00C3, ok);
    regRead(8'h0B, d, ok); chk("R3 ch3 readback", d, 16'h1234);
    regRead(8'h0F, d, ok); chk("R3 ch7 readback", d, 16'hBEEF);
    regRead(8'h03, d, ok); chk("R2 bcast reg write", d, 16'h00C3);
  endtask

  task automatic tLastWritten();
    logic [15:0] d; logic ok, a;
    regWrite(DEV, 8'h01, 16'h5A3C, ok);
    i2cStart(); sendByte({DEV, 1'b1}, a); recvByte(1'b1, d[15:8]); recvByte(1'b0, d[7:0]); i2cStop();
    chk("R4 address-only read ack", 16'(a), 16'h1);
    chk("R4 address-only read data", d, 16'h5A3C);
  endtask

  task automatic tBcastWrite();
    logic [15:0] d; logic ok;
    regWrite(BC, 8'h08, 16'h0F0F, ok); chk("R5 broadcast write acks", 16'(ok), 16'h1);
    regRead(8'h08, d, ok); chk("R5 broadcast write data", d, 16'h0F0F);
  endtask

  task automatic tBcastRead();
    logic [7:0] v; logic a;
    i2cStart(); sendByte({BC, 1'b1}, a); recvByte(1'b0, v); i2cStop();
    chk("R6 broadcast read nack", 16'(a), 16'h0);
    chk("R6 no data driven", 16'(v), 16'h00FF);
  endtask

  task automatic tForeign();
    logic [15:0] d; logic a, a1, ok;
    i2cStart(); sendByte({7'h22, 1'b0}, a); sendByte(8'h0B, a1); i2cStop();
    chk("R1 foreign address nack", 16'(a), 16'h0);
    chk("R1 ignored until start", 16'(a1), 16'h0);
    regRead(8'h0B, d, ok); chk("R1 register untouched", d, 16'h1234);
  endtask

  task automatic tStatusRO();
    logic [15:0] d; logic ok;
    regWrite(DEV, 8'h02, 16'hFFFF, ok); chk("R8 status write acked", 16'(ok), 16'h1);
    regRead(8'h02, d, ok); chk("R8 status unchanged", d, SID);
  endtask

  task automatic tUnmapped();
    logic [15:0] d; logic ok;
    regWrite(DEV, 8'h09, 16'h4444, ok);
    regWrite(DEV, 8'h20, 16'h7777, ok); chk("R10 unmapped write acked", 16'(ok), 16'h1);
    regRead(8'h20, d, ok); chk("R10 unmapped reads zero", d, 16'h0000); chk("R10 unmapped read acked", 16'(ok), 16'h1);
    regRead(8'h10, d, ok); chk("R10 past channels reads zero", d, 16'h0000);
    regRead(8'h09, d, ok); chk("R10 channel unchanged", d, 16'h4444);
  endtask

  task automatic tAbort();
    logic [15:0] d; logic ok, a;
    regWrite(DEV, 8'h0A, 16'h1111, ok);
    i2cStart(); sendByte({DEV, 1'b0}, a); sendByte(8'h0A, a); sendByte(8'h99, a); i2cStop();
    regRead(8'h0A, d, ok); chk("R2 aborted write discarded", d, 16'h1111);
  endtask

  task automatic tSoftRst();
    logic [15:0] d; logic ok;
    regWrite(DEV, 8'h01, 16'h1357, ok);
    regWrite(DEV, 8'h04, 16'h0000, ok);
    regRead(8'h01, d, ok); chk("R9 cfg restored", d, 16'h00FF);
    regRead(8'h0B, d, ok); chk("R9 channel cleared", d, 16'h0000);
    regRead(8'h03, d, ok); chk("R9 bcast cleared", d, 16'h0000);
    regRead(8'h04, d, ok); chk("R9 reset reg reads zero", d, 16'h0000);
  endtask

  task automatic tNackMsb();
    logic [7:0] v, w; logic ok, a;
    regWrite(DEV, 8'h0E, 16'hA55A, ok);
    i2cStart(); sendByte({DEV, 1'b1}, a); recvByte(1'b0, v); recvByte(1'b0, w); i2cStop();
    chk("R11 high byte before nack", 16'(v), 16'h00A5);
    chk("R11 released after nack", 16'(w), 16'h00FF);
  endtask

  task automatic tAfterLsb();
    logic [15:0] d; logic [7:0] x; logic a;
    i2cStart(); sendByte({DEV, 1'b0}, a); sendByte(8'h0E, a);
    i2cStart(); sendByte({DEV, 1'b1}, a);
    recvByte(1'b1, d[15:8]); recvByte(1'b1, d[7:0]); recvByte(1'b0, x); i2cStop();
    chk("R3 two-byte read", d, 16'hA55A);
    chk("R11 released after low byte", 16'(x), 16'h00FF);
  endtask

  task automatic tRestart();
    logic [15:0] d; logic ok;
    i2cStart(); bitOut(1'b1); bitOut(1'b0); bitOut(1'b1); bitOut(1'b1);
    regWrite(DEV, 8'h0C, 16'h6E6E, ok); chk("R13 restart write acks", 16'(ok), 16'h1);
    regRead(8'h0C, d, ok); chk("R13 restart write data", d, 16'h6E6E);
  endtask

  initial begin
    #3;
    #(CLK_PERIOD*5); rstN = 1'b1; #(CLK_PERIOD*5);
    chk("R7 sda released after reset", 16'(sdaOe), 16'h0);
    tReset(); tWriteRead(); tLastWritten(); tBcastWrite(); tBcastRead(); tForeign();
    tStatusRO(); tUnmapped(); tAbort(); tSoftRst(); tNackMsb(); tAfterLsb(); tRestart();
    chk("R12 sda moves while scl high", 16'(sclHighMoves), 16'h0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule